// File: doc/BRIEF.md
# Pin Direction and Output Level Controller

This block is a memory-mapped general-purpose I/O peripheral for 54 pads. It sits on a simple 32-bit register bus with a byte address, a write strobe, write data and combinational read data. For each pad it holds a 3-bit function code that makes the pad an input or a driven output. It also holds an output level bit and brings the pad's input level back through a synchronizer.

Function codes are packed ten to a 32-bit register word. To change one pad's code, software reads the word, changes the field and writes the whole word back. For that reason every stored field reads back exactly as written. Output levels are never written through a data register. A level is raised through a write-one-to-set word and lowered through a write-one-to-clear word. A single write therefore touches only the pads whose bits are 1, and no other pad can be changed by accident.

Pads 0–31 form bank 0 and pads 32–53 form bank 1. The pad driver is modelled as an output value plus an output enable.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Pad n's function code is stored in the register word at byte offset 4·(n/10), bits 3·(n mod 10)+2 down to 3·(n mod 10). The six code words sit at offsets 0x00 to 0x14. A write replaces all fields of that word, and a read returns them exactly.
- R2: Function code 3'b001 asserts the pad's output enable. Code 3'b000 (input) and every other code keep it deasserted. Output value and enable change only on a bus write.
- R3: Writing a 1 to bit i of the set word raises the output level on the next clock edge. Offset 0x1C covers pad i, and offset 0x20 covers pad 32+i for bits 21:0.
- R4: A 0 bit in a set-word write leaves that pad's output level unchanged.
- R5: Writing a 1 to bit i of the clear word lowers the output level, and a 0 bit leaves it unchanged. Offset 0x28 covers pad i, and offset 0x2C covers pad 32+i for bits 21:0.
- R6: The following bits are ignored on write and read as zero: bits 31:30 of every code word, the bits above the last pad in word 0x14 (31:12), and bits 31:22 of the bank-1 set and clear words.
- R7: The set and clear words are write-only and read as zero.
- R8: Offset 0x34 returns pad inputs 31:0, and offset 0x38 returns pad inputs 53:32 in bits 21:0. Both pass through a two-stage synchronizer, so a new pad value is readable after two rising clock edges and not after one.
- R9: After reset, every function code is 000, every output level is 0 and every output enable is 0.
- R10: A pad's output level can be changed while the pad is an input. The stored level appears with the enable as soon as the code becomes 001.
- R11: A read of an unmapped or misaligned offset returns zero, and a write to one changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pad_in | input | 54 | Pad input levels (asynchronous) |
| pad_out | output | 54 | Output level per pad |
| pad_oe | output | 54 | Output enable per pad |

## Verification
All-ones writes to the code words separate stored bits from reserved bits, because only the legal fields may come back. Mixed patterns (0x12345678, 0x2AAAAAAA) expose swapped or shifted fields.

Codes are placed on pads 9 and 10 to test the boundary between two words. Code 010 on a neighbouring pad tells "output code only" apart from "any nonzero code".

For set and clear, the patterns include zero bits beside one bits, a clear word of all zeros, and bank-1 writes with the upper bits set. These show whether zero bits are kept and whether out-of-range bits leak into other pads. The level words are read one and two edges after a pad change to confirm the synchronizer depth.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   // function codes held in each pad field
   localparam logic [2:0] FN_INPUT  = 3'b000;
   localparam logic [2:0] FN_OUTPUT = 3'b001;
   // word indices (byte offset / 4) of the banked register groups
   localparam int SET_BASE_WORD = 7;   // 0x1C
   localparam int CLR_BASE_WORD = 10;  // 0x28
   localparam int LVL_BASE_WORD = 13;  // 0x34
endpackage

// File: rtl/gpio_func_regs.sv
module gpio_func_regs
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS       = 54,
   parameter int FIELD_W        = 3,
   parameter int FIELDS_PER_REG = 10,
   parameter int WIDX_W         = 4,
   localparam int SEL_BITS      = FIELD_W * FIELDS_PER_REG
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [WIDX_W-1:0]   wr_word,
   input  logic [SEL_BITS-1:0] wr_data,
   input  logic [WIDX_W-1:0]   rd_word,
   output logic [SEL_BITS-1:0] rd_data,
   output logic [NUM_PINS-1:0] out_en
);
   logic [FIELD_W-1:0] fsel_q [NUM_PINS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int p = 0; p < NUM_PINS; p++) fsel_q[p] <= FIELD_W'(FN_INPUT);
      end else if (wr_en) begin
         for (int p = 0; p < NUM_PINS; p++) begin
            if (wr_word == WIDX_W'(p / FIELDS_PER_REG))
               fsel_q[p] <= wr_data[FIELD_W*(p % FIELDS_PER_REG) +: FIELD_W];
         end
      end
   end

   // repack the fields of the addressed word; unused slots stay zero
   always_comb begin
      rd_data = '0;
      for (int p = 0; p < NUM_PINS; p++) begin
         if (rd_word == WIDX_W'(p / FIELDS_PER_REG))
            rd_data[FIELD_W*(p % FIELDS_PER_REG) +: FIELD_W] = fsel_q[p];
      end
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_oe
      assign out_en[p] = (fsel_q[p] == FIELD_W'(FN_OUTPUT));
   end
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
   parameter int NUM_PINS = 54,
   parameter int DATA_W   = 32,
   parameter int WIDX_W   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                set_en,
   input  logic                clr_en,
   input  logic [WIDX_W-1:0]   bank_sel,
   input  logic [DATA_W-1:0]   wr_data,
   output logic [NUM_PINS-1:0] level_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= '0;
      end else begin
         for (int p = 0; p < NUM_PINS; p++) begin
            if (bank_sel == WIDX_W'(p / DATA_W) && wr_data[p % DATA_W]) begin
               if (set_en)      level_q[p] <= 1'b1;
               else if (clr_en) level_q[p] <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int NUM_PINS = 54,
   parameter int STAGES   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_sync
);
   if (STAGES < 2) begin : g_bad_depth
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= pad_in;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign pad_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS       = 54,
   parameter int DATA_W         = 32,
   parameter int ADDR_W         = 6,
   parameter int FIELD_W        = 3,
   parameter int FIELDS_PER_REG = 10,
   parameter int SYNC_STAGES    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe
);
   localparam int WIDX_W    = ADDR_W - 2;
   localparam int NUM_SEL   = (NUM_PINS + FIELDS_PER_REG - 1) / FIELDS_PER_REG;
   localparam int NUM_BANKS = (NUM_PINS + DATA_W - 1) / DATA_W;
   localparam int SEL_BITS  = FIELD_W * FIELDS_PER_REG;

   if (SEL_BITS > DATA_W) begin : g_bad_pack
      $error("gpio_bank_ctrl: packed fields exceed the data width");
   end
   if (NUM_SEL > SET_BASE_WORD || SET_BASE_WORD + NUM_BANKS > CLR_BASE_WORD ||
       CLR_BASE_WORD + NUM_BANKS > LVL_BASE_WORD) begin : g_bad_map
      $error("gpio_bank_ctrl: register groups overlap");
   end
   if (LVL_BASE_WORD + NUM_BANKS > (1 << WIDX_W)) begin : g_bad_addr
      $error("gpio_bank_ctrl: address too narrow for the register map");
   end

   logic [WIDX_W-1:0] word;
   logic              aligned, sel_hit, set_hit, clr_hit, lvl_hit;
   logic [WIDX_W-1:0] bank_sel;
   logic [SEL_BITS-1:0] sel_rd;
   logic [NUM_PINS-1:0] pad_sync;
   logic [NUM_BANKS*DATA_W-1:0] lvl_wide;
   int                lvl_idx;

   assign word    = bus_addr[ADDR_W-1:2];
   assign aligned = (bus_addr[1:0] == 2'b00);
   assign sel_hit = aligned && (int'(word) < NUM_SEL);
   assign set_hit = aligned && (int'(word) >= SET_BASE_WORD) &&
                    (int'(word) < SET_BASE_WORD + NUM_BANKS);
   assign clr_hit = aligned && (int'(word) >= CLR_BASE_WORD) &&
                    (int'(word) < CLR_BASE_WORD + NUM_BANKS);
   assign lvl_hit = aligned && (int'(word) >= LVL_BASE_WORD) &&
                    (int'(word) < LVL_BASE_WORD + NUM_BANKS);
   assign bank_sel = set_hit ? word - WIDX_W'(SET_BASE_WORD)
                             : word - WIDX_W'(CLR_BASE_WORD);
   assign lvl_idx  = int'(word) - LVL_BASE_WORD;

   gpio_func_regs #(
      .NUM_PINS(NUM_PINS), .FIELD_W(FIELD_W),
      .FIELDS_PER_REG(FIELDS_PER_REG), .WIDX_W(WIDX_W)
   ) u_func (
      .clk(clk), .rst_n(rst_n),
      .wr_en(bus_wr && sel_hit), .wr_word(word),
      .wr_data(bus_wdata[SEL_BITS-1:0]),
      .rd_word(word), .rd_data(sel_rd), .out_en(pad_oe)
   );

   gpio_out_latch #(
      .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .WIDX_W(WIDX_W)
   ) u_latch (
      .clk(clk), .rst_n(rst_n),
      .set_en(bus_wr && set_hit), .clr_en(bus_wr && clr_hit),
      .bank_sel(bank_sel), .wr_data(bus_wdata), .level_q(pad_out)
   );

   gpio_in_sync #(
      .NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pad_sync(pad_sync)
   );

   always_comb begin
      lvl_wide = '0;
      lvl_wide[NUM_PINS-1:0] = pad_sync;
   end

   always_comb begin
      bus_rdata = '0;
      if (sel_hit)
         bus_rdata[SEL_BITS-1:0] = sel_rd;
      else if (lvl_hit)
         bus_rdata = lvl_wide[lvl_idx*DATA_W +: DATA_W];
   end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
   parameter int NUM_PINS = 54
) (
   input logic                clk,
   input logic                rst_n,
   input logic [5:0]          bus_addr,
   input logic                bus_wr,
   input logic [31:0]         bus_wdata,
   input logic [31:0]         bus_rdata,
   input logic [NUM_PINS-1:0] pad_out,
   input logic [NUM_PINS-1:0] pad_oe
);
   AST_SET_LOW_BANK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 6'h1C) |=> ((pad_out[31:0] & $past(bus_wdata)) == $past(bus_wdata))); // R3

   AST_SET_HIGH_BANK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 6'h20) |=>
         ((pad_out[NUM_PINS-1:32] & $past(bus_wdata[NUM_PINS-33:0])) == $past(bus_wdata[NUM_PINS-33:0]))); // R3

   AST_SET_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 6'h1C) |=>
         ((pad_out[31:0] & ~$past(bus_wdata)) == ($past(pad_out[31:0]) & ~$past(bus_wdata)))); // R4

   AST_CLR_LOW_BANK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 6'h28) |=> ((pad_out[31:0] & $past(bus_wdata)) == 32'h0)); // R5

   AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> ($stable(pad_out) && $stable(pad_oe))); // R2

   AST_SEL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 6'h00 || bus_addr == 6'h04 || bus_addr == 6'h08) |-> (bus_rdata[31:30] == 2'b00)); // R6

   AST_SETCLR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 6'h1C || bus_addr == 6'h20 || bus_addr == 6'h28 || bus_addr == 6'h2C)
         |-> (bus_rdata == 32'h0)); // R7
endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (.*);

// File: tb/gpio_bank_ctrl_bench.sv
module gpio_bank_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [5:0]  bus_addr;
   logic        bus_wr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic [53:0] pad_in;
   logic [53:0] pad_out;
   logic [53:0] pad_oe;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk; // 50 MHz

   gpio_bank_ctrl u_gpio_bank_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe)
   );

   // {is_read, addr, data (write value or expected read), requirement}
   localparam int NVEC = 16;
   localparam logic [42:0] VEC [NVEC] = '{
      {1'b0, 6'h00, 32'hFFFF_FFFF, 4'd1},
      {1'b1, 6'h00, 32'h3FFF_FFFF, 4'd6},   // R6 bits 31:30 dropped
      {1'b0, 6'h04, 32'h1234_5678, 4'd1},
      {1'b1, 6'h04, 32'h1234_5678, 4'd1},   // R1 exact readback
      {1'b0, 6'h08, 32'h2AAA_AAAA, 4'd1},
      {1'b1, 6'h08, 32'h2AAA_AAAA, 4'd1},
      {1'b0, 6'h14, 32'hFFFF_FFFF, 4'd6},
      {1'b1, 6'h14, 32'h0000_0FFF, 4'd6},   // R6 only pads 50..53 stored
      {1'b1, 6'h1C, 32'h0000_0000, 4'd7},   // R7
      {1'b1, 6'h2C, 32'h0000_0000, 4'd7},
      {1'b1, 6'h18, 32'h0000_0000, 4'd11},  // R11 unmapped
      {1'b0, 6'h00, 32'h0000_0000, 4'd1},
      {1'b1, 6'h00, 32'h0000_0000, 4'd1},
      {1'b0, 6'h04, 32'h0000_0000, 4'd1},
      {1'b0, 6'h08, 32'h0000_0000, 4'd1},
      {1'b0, 6'h14, 32'h0000_0000, 4'd1}
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 reset state
      bus_read(6'h00, rd);
      check("R9 code word 0", 64'(rd), 64'h0);
      check("R9 enables", 64'(pad_oe), 64'h0);
      check("R9 levels", 64'(pad_out), 64'h0);

      // R8 synchronizer depth
      pad_in = {22'h15_5555, 32'hDEAD_BEEF};
      @(negedge clk);
      bus_read(6'h34, rd);
      check("R8 one edge", 64'(rd), 64'h0);
      @(negedge clk);
      bus_read(6'h34, rd);
      check("R8 bank 0 level", 64'(rd), 64'hDEAD_BEEF);
      bus_read(6'h38, rd);
      check("R8 bank 1 level", 64'(rd), 64'h0015_5555);

      // table walk
      for (int i = 0; i < NVEC; i++) begin
         if (VEC[i][42]) begin
            bus_read(VEC[i][41:36], rd);
            check($sformatf("R%0d vector %0d", VEC[i][3:0], i), 64'(rd), 64'(VEC[i][35:4]));
         end else begin
            bus_write(VEC[i][41:36], VEC[i][35:4]);
         end
      end
      check("R2 enables after table", 64'(pad_oe), 64'h0);

      // R1/R2: pad 5 output, pad 6 code 010, pad 9 output
      bus_write(6'h00, 32'h0808_8000);
      check("R2 only code 001 drives", 64'(pad_oe), 64'h220);
      bus_write(6'h04, 32'h0000_0001);  // R1 pad 10 in next word
      check("R1 word boundary", 64'(pad_oe), 64'h620);

      // R3/R4 set, R5 clear
      bus_write(6'h1C, 32'h0000_0021);
      check("R3 set bank 0", 64'(pad_out), 64'h21);
      bus_write(6'h1C, 32'h0000_0100);
      check("R4 zeros kept", 64'(pad_out), 64'h121);
      bus_write(6'h28, 32'h0000_0001);
      check("R5 clear bank 0", 64'(pad_out), 64'h120);
      bus_write(6'h28, 32'h0000_0000);
      check("R5 zero clear", 64'(pad_out), 64'h120);
      bus_write(6'h20, 32'hFFFF_FFFF);
      check("R3 set bank 1", 64'(pad_out), {10'h0, 22'h3F_FFFF, 32'h120});
      bus_write(6'h2C, 32'hFFE0_0001);
      check("R5 clear bank 1", 64'(pad_out), {10'h0, 22'h1F_FFFE, 32'h120});

      // R11 misaligned write ignored
      bus_write(6'h1D, 32'hFFFF_FFFF);
      check("R11 misaligned write", 64'(pad_out), {10'h0, 22'h1F_FFFE, 32'h120});

      // R10 level stored while input, shows when enabled
      check("R10 pad 40 not driven", {63'h0, pad_oe[40]}, 64'h0);
      bus_write(6'h10, 32'h0000_0001);
      check("R10 pad 40 enabled", {62'h0, pad_oe[40], pad_out[40]}, 64'h3);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule